// File: doc/BRIEF.md
# Sequencer Start Control with Programmable Delay

This block produces the single-cycle internal start pulse that launches an address sequence. A start can be asked for in three ways: a one-cycle software strobe from the configuration logic, the release of an active-low external start pin, or the terminal-address strobe from the address generator when the restart-on-finish mode is on. Each request arms a down-counter. The pulse fires once the programmed delay of 1 to 31 clocks has run out.

Alongside the pulse, the block drives an active-low start-out pin that other chips can use to start in step. This pin only pulses for starts raised inside the chip (software or restart), so a chain of chips never echoes a start back to the chip that sent it. The block also drives an active-low address-valid strobe, which marks the cycle in which the first address of the new sequence reaches the outputs. That cycle is a fixed pipeline latency after the start.

Top module: `seq_start_ctrl`

## Requirements
- R1: While reset is applied, and until the first request after it, start_o is 0, start_out_n_o is 1 and addr_valid_n_o is 1.
- R2: A software request (sw_start_i sampled 1 at a clock edge) makes start_o high for exactly one cycle, beginning D edges after the edge that sampled the request.
- R3: An external request is the first edge at which ext_start_n_i is sampled 1 after having been sampled 0. A low interval of any length yields exactly one start.
- R4: seq_last_i sampled 1 while restart_en_i is 1 is a request. When restart_en_i is 0, seq_last_i yields no start.
- R5: D is the value of dly_i sampled at the request edge, in the range 1 to 31. A value of 0 gives D = 1.
- R6: A request arriving while an earlier start is still pending reloads the count with its own D and replaces the earlier start. Overlapping requests give one start.
- R7: start_out_n_o is low in the same cycle as start_o when the request that armed it included a software or restart source. A start armed only by the external pin leaves start_out_n_o high.
- R8: addr_valid_n_o is low for exactly one cycle, FIRST_LAT edges after the cycle in which start_o is high (FIRST_LAT = 2 by default).
- R9: start_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_start_i | input | 1 | One-cycle software start strobe |
| ext_start_n_i | input | 1 | Active-low external start pin, acts on release |
| restart_en_i | input | 1 | Restart-on-finish mode enable |
| seq_last_i | input | 1 | Terminal-address strobe from the address generator |
| dly_i | input | DLY_W | Start delay in clocks (0 acts as 1) |
| start_o | output | 1 | Internal start pulse to the address generator |
| start_out_n_o | output | 1 | Active-low start-out for other chips |
| addr_valid_n_o | output | 1 | Active-low first-address-valid strobe |

## Verification
The hardest situation to reach from the ports is a new request landing while a long delay is still counting down, especially when its source differs from the pending one. Only that case shows whether the count reloads and whether the start-out tag is replaced. Random stimulus is biased towards large delays and frequent, mixed-source requests, so these collisions occur often. A directed case also arms an internal start with a long delay and then overtakes it with a short external release.

// File: rtl/seq_start_pkg.sv
package seq_start_pkg;
  // one merged start request for a clock cycle
  typedef struct packed {
    logic valid;     // some source asks for a start
    logic internal;  // software or restart source present
  } start_req_t;
endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic r1_q, r2_q;
  logic r1_d, r2_d;

  always_comb begin
    r1_d = 1'b1;
    r2_d = r1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= r1_d;
      r2_q <= r2_d;
    end
  end

  assign rst_n_sync = r2_q;
endmodule

// File: rtl/ssc_req_src.sv
module ssc_req_src
  import seq_start_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start_i,
  input  logic       ext_start_n_i,
  input  logic       restart_en_i,
  input  logic       seq_last_i,
  output start_req_t req_o
);
  logic ext_prev_q, ext_prev_d;
  logic ext_rel;
  logic restart_req;

  always_comb begin
    ext_prev_d  = ext_start_n_i;
    ext_rel     = !ext_prev_q && ext_start_n_i;
    restart_req = restart_en_i && seq_last_i;
    req_o.valid    = sw_start_i || ext_rel || restart_req;
    req_o.internal = sw_start_i || restart_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= ext_prev_d;
  end

  // R3: an external request only follows a sampled low then high
  assert_ext_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rel |-> ($past(ext_start_n_i) == 1'b0 && ext_start_n_i)));

  // R4: restart strobe without mode enable never forms a request alone
  assert_restart_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!restart_en_i && !sw_start_i && ext_prev_q) |-> !req_o.valid));
endmodule

// File: rtl/ssc_delay_timer.sv
module ssc_delay_timer
  import seq_start_pkg::*;
#(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  start_req_t       req_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             start_o,
  output logic             start_int_o
);
  localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;

  logic [DLY_W-1:0] cnt_q, cnt_d, eff_dly;
  logic             tag_q, tag_d;
  logic             start_q, start_d;
  logic             sint_q, sint_d;
  logic             cnt_en;

  always_comb begin
    eff_dly = (dly_i == CNT_ZERO) ? CNT_ONE : dly_i;
    cnt_en  = req_i.valid || (cnt_q != CNT_ZERO);
    cnt_d   = cnt_q;
    tag_d   = tag_q;
    start_d = 1'b0;
    sint_d  = 1'b0;
    if (req_i.valid) begin
      cnt_d = eff_dly;
      tag_d = req_i.internal;
    end else if (cnt_q == CNT_ONE) begin
      cnt_d   = CNT_ZERO;
      start_d = 1'b1;
      sint_d  = tag_q;
    end else if (cnt_q != CNT_ZERO) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
      tag_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sint_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      sint_q  <= sint_d;
    end
  end

  assign start_o     = start_q;
  assign start_int_o = sint_q;

  // R9: the start pulse is a single cycle
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q |=> !start_q));

  // R6: a fresh request always defers the start by at least one cycle
  assert_req_defers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.valid |=> !start_q));

  // R7: an internal-start mark only accompanies a start
  assert_int_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sint_q |-> start_q));
endmodule

// File: rtl/ssc_out_stage.sv
module ssc_out_stage #(
  parameter int FIRST_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_int_i,
  output logic start_out_n_o,
  output logic addr_valid_n_o
);
  logic [FIRST_LAT-1:0] vpipe_q, vpipe_d;

  generate
    if (FIRST_LAT == 1) begin : g_lat1
      always_comb vpipe_d = start_i;
    end else begin : g_latn
      always_comb vpipe_d = {vpipe_q[FIRST_LAT-2:0], start_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe_q <= '0;
    else        vpipe_q <= vpipe_d;
  end

  assign start_out_n_o  = !start_int_i;
  assign addr_valid_n_o = !vpipe_q[FIRST_LAT-1];

  // R8: the first-address strobe lasts one cycle
  assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid_n_o |=> addr_valid_n_o));
endmodule

// File: rtl/seq_start_ctrl.sv
module seq_start_ctrl
  import seq_start_pkg::*;
#(
  parameter int DLY_W     = 5,
  parameter int FIRST_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start_i,
  input  logic             ext_start_n_i,
  input  logic             restart_en_i,
  input  logic             seq_last_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             start_o,
  output logic             start_out_n_o,
  output logic             addr_valid_n_o
);
  logic       rst_n_int;
  start_req_t req;
  logic       start_int;

  ssc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ssc_req_src u_src (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .sw_start_i    (sw_start_i),
    .ext_start_n_i (ext_start_n_i),
    .restart_en_i  (restart_en_i),
    .seq_last_i    (seq_last_i),
    .req_o         (req)
  );

  ssc_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_i       (req),
    .dly_i       (dly_i),
    .start_o     (start_o),
    .start_int_o (start_int)
  );

  ssc_out_stage #(.FIRST_LAT(FIRST_LAT)) u_out (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .start_i        (start_o),
    .start_int_i    (start_int),
    .start_out_n_o  (start_out_n_o),
    .addr_valid_n_o (addr_valid_n_o)
  );

  // R1: outputs stay idle while the internal reset is held
  assert_idle_in_reset_R1: assert property (@(posedge clk)
    (!rst_n_int |-> (!start_o && start_out_n_o && addr_valid_n_o)));
endmodule

// File: tb/seq_start_ctrl_tb.sv
module seq_start_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw = 1'b0, ext_n = 1'b1, ren = 1'b0, last = 1'b0;
  logic [4:0] dly = 5'd1;
  logic       st, so_n, av_n;

  int vectors = 0, errors = 0;
  int n_start = 0, n_so = 0;
  bit chk_en = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  seq_start_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start_i(sw), .ext_start_n_i(ext_n),
    .restart_en_i(ren), .seq_last_i(last), .dly_i(dly),
    .start_o(st), .start_out_n_o(so_n), .addr_valid_n_o(av_n)
  );

  // reference model built from the requirements
  logic m_r1, m_r2, m_prev, m_tag, m_st, m_so_n, m_v0, m_v1;
  int   m_cnt;

  function automatic int eff_delay(input logic [4:0] d);
    return (d == 5'd0) ? 1 : int'(d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 0; m_r2 <= 0; m_prev <= 1; m_tag <= 0; m_cnt <= 0;
      m_st <= 0; m_so_n <= 1; m_v0 <= 0; m_v1 <= 0;
    end else begin
      m_r1 <= 1; m_r2 <= m_r1;
      if (m_r2) begin
        automatic logic rel  = !m_prev && ext_n;
        automatic logic intl = sw || (ren && last);
        m_prev <= ext_n;
        m_v0 <= m_st; m_v1 <= m_v0;
        m_st <= 0; m_so_n <= 1;
        if (rel || intl) begin
          m_cnt <= eff_delay(dly); m_tag <= intl;
        end else if (m_cnt == 1) begin
          m_cnt <= 0; m_st <= 1; m_so_n <= !m_tag;
        end else if (m_cnt != 0) m_cnt <= m_cnt - 1;
      end
    end
  end

  logic prev_st = 1'b0;
  always @(negedge clk) begin
    if (chk_en) begin
      vectors++;
      if (st !== m_st) begin errors++; $display("FAIL %s start_o got %b exp %b", tag, st, m_st); end
      if (so_n !== m_so_n) begin errors++; $display("FAIL %s start_out_n got %b exp %b", tag, so_n, m_so_n); end
      if (av_n !== !m_v1) begin errors++; $display("FAIL %s (R8) addr_valid_n got %b exp %b", tag, av_n, !m_v1); end
      if (st && prev_st) begin errors++; $display("FAIL R9 start_o high twice got 1 exp 0"); end
      if (st) n_start++;
      if (!so_n) n_so++;
    end
    prev_st = st;
  end

  task automatic check(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin errors++; $display("FAIL %s got %b exp %b", req, got, exp); end
  endtask

  task automatic check_cnt(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin errors++; $display("FAIL %s got %0d exp %0d", req, got, exp); end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // software start with delay d, timing checked directly (R2 R5 R7 R8)
  task automatic sw_timed(input logic [4:0] d);
    int dd = eff_delay(d);
    @(negedge clk); #1 dly = d; sw = 1;
    @(negedge clk); #1 sw = 0;
    repeat (dd - 1) @(negedge clk);
    check("R2 R5 start early", st, 1'b0);
    @(negedge clk);
    check("R2 R5 start on time", st, 1'b1);
    check("R7 start_out with sw", so_n, 1'b0);
    @(negedge clk);
    check("R2 one cycle", st, 1'b0);
    check("R8 valid early", av_n, 1'b1);
    @(negedge clk);
    check("R8 valid on time", av_n, 1'b0);
    @(negedge clk);
    check("R8 valid one cycle", av_n, 1'b1);
  endtask

  initial begin
    int ext_hold = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 start_o in reset", st, 1'b0);
    check("R1 start_out_n in reset", so_n, 1'b1);
    check("R1 addr_valid_n in reset", av_n, 1'b1);
    #1 rst_n = 1;
    chk_en = 1;
    idle(4);
    check("R1 idle after reset", st, 1'b0);

    tag = "R2 R5";
    sw_timed(5'd0);
    sw_timed(5'd7);
    sw_timed(5'd31);

    // R3: long low on the external pin gives one start, no start-out
    tag = "R3"; n_start = 0; n_so = 0;
    @(negedge clk); #1 dly = 5'd2; ext_n = 0;
    idle(9); #1 ext_n = 1;
    idle(12);
    check_cnt("R3 one start per low interval", n_start, 1);
    check_cnt("R7 no start-out for external start", n_so, 0);

    // R4: restart strobe with mode off is ignored, with mode on starts
    tag = "R4"; n_start = 0; n_so = 0;
    @(negedge clk); #1 ren = 0; last = 1; dly = 5'd3;
    @(negedge clk); #1 last = 0;
    idle(10);
    check_cnt("R4 restart ignored when disabled", n_start, 0);
    @(negedge clk); #1 ren = 1; last = 1;
    @(negedge clk); #1 last = 0; ren = 0;
    idle(10);
    check_cnt("R4 restart starts when enabled", n_start, 1);
    check_cnt("R7 start-out on restart", n_so, 1);

    // R6: long software delay overtaken by a short external release
    tag = "R6"; n_start = 0; n_so = 0;
    @(negedge clk); #1 dly = 5'd20; sw = 1;
    @(negedge clk); #1 sw = 0;
    idle(4); #1 ext_n = 0; dly = 5'd3;
    @(negedge clk); #1 ext_n = 1;
    idle(40);
    check_cnt("R6 overlapping requests give one start", n_start, 1);
    check_cnt("R6 R7 replaced tag suppresses start-out", n_so, 0);

    // random phase, checked every cycle against the model
    tag = "R2 R3 R4 R5 R6 R7";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); #1;
      sw   = ($urandom % 18) == 0;
      ren  = $urandom % 2;
      last = ($urandom % 14) == 0;
      dly  = (($urandom % 3) == 0) ? 5'($urandom % 4) : 5'($urandom);
      if (ext_hold > 0) begin ext_hold--; ext_n = (ext_hold == 0); end
      else if (($urandom % 25) == 0) begin ext_n = 0; ext_hold = 1 + $urandom % 6; end
      else ext_n = 1;
    end
    sw = 0; last = 0; ext_n = 1;
    idle(40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule